// File: doc/BRIEF.md
# Multiplexed LED Column Refresh with Pulse-Width Brightness

This block drives a column-multiplexed LED dot array built from a row of character cells, each cell a few columns wide and eight rows tall. It takes a full image held in a flat dot-latch vector, a 4-bit duty code, a sleep flag and a peak-current code. It scans the array one column at a time and brings out a one-hot column select together with the row enables of the active column. Every column owns a slot of sixteen PWM ticks. The row enables are live only in the first N ticks of that slot, where N is the duty code, so the duty code sets the perceived brightness.

The lowest row of every column is held in the image but has no LED, so only the upper seven rows are driven. The image is copied into a private frame buffer only at the boundary between two full scans, so a frame never mixes an old image with a new one. Sleep blanks all outputs at once while the scan keeps its position. The peak-current code is only registered on its way to an external current driver. A tick prescaler lets the scan run slower than the system clock.

Top module: `dmx_column_refresh`

## Requirements
- R1: While `rst_n` is low, `col_sel`, `row_en` and `peak_out` are all zero. After release the scan starts in column 0 at tick 0 of its slot, and the frame buffer holds an all-zero image.
- R2: A column slot lasts 16 ticks. The columns are visited in ascending order 0, 1, … 19 and then wrap to 0.
- R3: `col_sel` is one-hot when awake, and bit n is set while column n is active. Every output is registered, so it reflects the scan state, the image and the control inputs sampled at the previous rising clock edge.
- R4: For column n, `row_en[i]` (i = 0..6) shows image bit 8n+1+i, which is row i+1. Image bit 8n (row 0) never reaches any output.
- R5: Within a slot the row enables are passed for ticks 0..N-1 and forced to zero for ticks N..15, where N is `duty`. A duty of 0 keeps every row dark, and a duty of 15 lights 15 of 16 ticks.
- R6: When `sleep` is 1, the next `col_sel` and `row_en` are both zero. The scan position keeps advancing during sleep.
- R7: `dot_latch` is captured only at the clock edge that ends tick 15 of column 19. A change at any other time shows up only from the next frame. The first frame after reset is dark.
- R8: `peak_out` equals `peak_code` delayed by one clock.
- R9: With prescale setting `TICK_DIV` = D, the scan advances once every D clocks, so a slot lasts 16·D clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dot_latch | input | 160 | Image, 8 bits per column, column 0 in bits 7..0 |
| duty | input | 4 | On-time code, ticks per 16-tick slot |
| sleep | input | 1 | 1 blanks all LED outputs |
| peak_code | input | 2 | Peak-current code for the external driver |
| col_sel | output | 20 | One-hot active column |
| row_en | output | 7 | Row enables for rows 1..7 of the active column |
| peak_out | output | 2 | Registered peak-current code |

## Verification
Two events can land on the same clock edge: a new image being taken at the frame boundary, and a change of duty or sleep. The bench changes the image in the middle of a frame and again near the last slot. It toggles sleep and sweeps the duty across frame boundaries, so the capture and the gating are sometimes decided on the same edge. Each is judged against a cycle model built from the requirements. A change of image must show only from the next frame. The gating must apply to the very next output, whether or not a capture happened on that edge.

// File: rtl/dmx_refresh_pkg.sv
package dmx_refresh_pkg;

   typedef enum logic {
      PWR_AWAKE  = 1'b0,
      PWR_ASLEEP = 1'b1
   } pwr_mode_e;

   function automatic int unsigned width_for(input int unsigned count);
      int unsigned w;
      w = 1;
      while ((1 << w) < count) w++;
      return w;
   endfunction

endpackage

// File: rtl/dmx_tick_gen.sv
module dmx_tick_gen #(
   parameter int unsigned TICK_DIV = 1
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);
   localparam int unsigned CNT_W = dmx_refresh_pkg::width_for(TICK_DIV);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(TICK_DIV - 1);

   logic [CNT_W-1:0] div_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         div_cnt <= '0;
      else if (div_cnt == LAST)
         div_cnt <= '0;
      else
         div_cnt <= div_cnt + 1'b1;
   end

   assign tick = (div_cnt == LAST);
endmodule

// File: rtl/dmx_scan_seq.sv
module dmx_scan_seq #(
   parameter int unsigned NCOLS  = 20,
   parameter int unsigned DUTY_W = 4
) (
   input  logic                                            clk,
   input  logic                                            rst_n,
   input  logic                                            tick,
   output logic [DUTY_W-1:0]                               slot_pos,
   output logic [dmx_refresh_pkg::width_for(NCOLS)-1:0]    col_idx,
   output logic                                            frame_end
);
   localparam int unsigned COL_W = dmx_refresh_pkg::width_for(NCOLS);
   localparam logic [COL_W-1:0]  COL_LAST  = COL_W'(NCOLS - 1);
   localparam logic [DUTY_W-1:0] SLOT_LAST = '1;

   logic slot_done;
   assign slot_done = tick && (slot_pos == SLOT_LAST);
   assign frame_end = slot_done && (col_idx == COL_LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         slot_pos <= '0;
         col_idx  <= '0;
      end else if (tick) begin
         slot_pos <= slot_pos + 1'b1;
         if (slot_done)
            col_idx <= (col_idx == COL_LAST) ? '0 : col_idx + 1'b1;
      end
   end
endmodule

// File: rtl/dmx_frame_buf.sv
module dmx_frame_buf #(
   parameter int unsigned WIDTH = 140
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [WIDTH-1:0] img_in,
   output logic [WIDTH-1:0] img_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         img_q <= '0;
      else if (load)
         img_q <= img_in;
   end
endmodule

// File: rtl/dmx_row_drive.sv
module dmx_row_drive #(
   parameter int unsigned NCOLS    = 20,
   parameter int unsigned LIT_ROWS = 7,
   parameter int unsigned DUTY_W   = 4,
   parameter int unsigned CURR_W   = 2
) (
   input  logic                                         clk,
   input  logic                                         rst_n,
   input  logic [NCOLS*LIT_ROWS-1:0]                    img,
   input  logic [dmx_refresh_pkg::width_for(NCOLS)-1:0] col_idx,
   input  logic [DUTY_W-1:0]                            slot_pos,
   input  logic [DUTY_W-1:0]                            duty,
   input  logic                                         sleep,
   input  logic [CURR_W-1:0]                            peak_code,
   output logic [NCOLS-1:0]                             col_sel,
   output logic [LIT_ROWS-1:0]                          row_en,
   output logic [CURR_W-1:0]                            peak_out
);
   import dmx_refresh_pkg::*;
   localparam int unsigned COL_W = width_for(NCOLS);

   logic [LIT_ROWS-1:0] col_word [NCOLS];
   logic [NCOLS-1:0]    col_hot;
   pwr_mode_e           mode;
   logic                on_phase;

   for (genvar c = 0; c < NCOLS; c++) begin : g_col
      assign col_word[c] = img[c*LIT_ROWS +: LIT_ROWS];
      assign col_hot[c]  = (col_idx == COL_W'(c));
   end

   assign mode     = sleep ? PWR_ASLEEP : PWR_AWAKE;
   assign on_phase = (slot_pos < duty);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         col_sel  <= '0;
         row_en   <= '0;
         peak_out <= '0;
      end else begin
         peak_out <= peak_code;
         if (mode == PWR_ASLEEP) begin
            col_sel <= '0;
            row_en  <= '0;
         end else begin
            col_sel <= col_hot;
            row_en  <= on_phase ? col_word[col_idx] : '0;
         end
      end
   end
endmodule

// File: rtl/dmx_column_refresh.sv
module dmx_column_refresh #(
   parameter int unsigned N_CELLS   = 4,
   parameter int unsigned CELL_COLS = 5,
   parameter int unsigned CELL_ROWS = 8,
   parameter int unsigned DUTY_W    = 4,
   parameter int unsigned CURR_W    = 2,
   parameter int unsigned TICK_DIV  = 1
) (
   input  logic                                   clk,
   input  logic                                   rst_n,
   input  logic [N_CELLS*CELL_COLS*CELL_ROWS-1:0] dot_latch,
   input  logic [DUTY_W-1:0]                      duty,
   input  logic                                   sleep,
   input  logic [CURR_W-1:0]                      peak_code,
   output logic [N_CELLS*CELL_COLS-1:0]           col_sel,
   output logic [CELL_ROWS-2:0]                   row_en,
   output logic [CURR_W-1:0]                      peak_out
);
   localparam int unsigned NCOLS    = N_CELLS * CELL_COLS;
   localparam int unsigned LIT_ROWS = CELL_ROWS - 1;
   localparam int unsigned IMG_W    = NCOLS * LIT_ROWS;
   localparam int unsigned COL_W    = dmx_refresh_pkg::width_for(NCOLS);

   if (N_CELLS < 1 || CELL_COLS < 1) begin : g_bad_geom
      $error("dmx_column_refresh: array needs at least one column");
   end
   if (CELL_ROWS < 2) begin : g_bad_rows
      $error("dmx_column_refresh: needs a lit row above row 0");
   end
   if (DUTY_W < 1 || DUTY_W > 8) begin : g_bad_duty
      $error("dmx_column_refresh: DUTY_W out of range 1..8");
   end
   if (TICK_DIV < 1) begin : g_bad_div
      $error("dmx_column_refresh: TICK_DIV must be at least 1");
   end
   if (CURR_W < 1) begin : g_bad_curr
      $error("dmx_column_refresh: CURR_W must be at least 1");
   end

   logic [IMG_W-1:0]  lit_img;
   logic [NCOLS-1:0]  row0_bits;
   logic              row0_unused;

   for (genvar c = 0; c < NCOLS; c++) begin : g_pack
      assign row0_bits[c] = dot_latch[c*CELL_ROWS];
      assign lit_img[c*LIT_ROWS +: LIT_ROWS] = dot_latch[c*CELL_ROWS+1 +: LIT_ROWS];
   end
   assign row0_unused = ^row0_bits;

   logic              tick;
   logic [DUTY_W-1:0] slot_pos;
   logic [COL_W-1:0]  col_idx;
   logic              frame_end;
   logic [IMG_W-1:0]  frame_img;

   dmx_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (tick)
   );

   dmx_scan_seq #(.NCOLS(NCOLS), .DUTY_W(DUTY_W)) u_scan (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (tick),
      .slot_pos  (slot_pos),
      .col_idx   (col_idx),
      .frame_end (frame_end)
   );

   dmx_frame_buf #(.WIDTH(IMG_W)) u_fbuf (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (frame_end),
      .img_in (lit_img),
      .img_q  (frame_img)
   );

   dmx_row_drive #(
      .NCOLS(NCOLS), .LIT_ROWS(LIT_ROWS), .DUTY_W(DUTY_W), .CURR_W(CURR_W)
   ) u_drive (
      .clk       (clk),
      .rst_n     (rst_n),
      .img       (frame_img),
      .col_idx   (col_idx),
      .slot_pos  (slot_pos),
      .duty      (duty),
      .sleep     (sleep),
      .peak_code (peak_code),
      .col_sel   (col_sel),
      .row_en    (row_en),
      .peak_out  (peak_out)
   );
endmodule

// File: rtl/dmx_column_refresh_chk.sv
module dmx_column_refresh_chk #(
   parameter int unsigned NCOLS    = 20,
   parameter int unsigned LIT_ROWS = 7,
   parameter int unsigned DUTY_W   = 4,
   parameter int unsigned CURR_W   = 2
) (
   input logic                clk,
   input logic                rst_n,
   input logic [DUTY_W-1:0]   duty,
   input logic                sleep,
   input logic [CURR_W-1:0]   peak_code,
   input logic [NCOLS-1:0]    col_sel,
   input logic [LIT_ROWS-1:0] row_en,
   input logic [CURR_W-1:0]   peak_out
);
   assert_col_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(col_sel));

   assert_sleep_blank_R6: assert property (@(posedge clk) disable iff (!rst_n)
      sleep |=> (col_sel == '0 && row_en == '0));

   assert_zero_duty_dark_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (duty == '0) |=> (row_en == '0));

   assert_rows_need_column_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (row_en != '0) |-> (col_sel != '0));

   assert_peak_delay_R8: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (peak_out == $past(peak_code)));

   always @(posedge clk) begin
      if (!rst_n) begin
         assert_reset_quiet_R1: assert (col_sel == '0 && row_en == '0 && peak_out == '0);
      end
   end
endmodule

bind dmx_column_refresh dmx_column_refresh_chk #(
   .NCOLS(N_CELLS*CELL_COLS), .LIT_ROWS(CELL_ROWS-1), .DUTY_W(DUTY_W), .CURR_W(CURR_W)
) i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .duty      (duty),
   .sleep     (sleep),
   .peak_code (peak_code),
   .col_sel   (col_sel),
   .row_en    (row_en),
   .peak_out  (peak_out)
);

// File: tb/test_dmx_column_refresh.sv
module test_dmx_column_refresh;
   localparam int NC = 20;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [159:0] dot_latch = '0;
   logic [3:0]   duty = '0;
   logic         sleep = 1'b0;
   logic [1:0]   peak_code = '0;
   logic [19:0]  col_sel, col_sel_d;
   logic [6:0]   row_en, row_en_d;
   logic [1:0]   peak_out, peak_out_d;

   int checks = 0;
   int errors = 0;
   bit checking = 1'b0;
   string row_tag = "R4";

   always #2 clk = ~clk;

   dmx_column_refresh i_dmx_column_refresh (
      .clk(clk), .rst_n(rst_n), .dot_latch(dot_latch), .duty(duty), .sleep(sleep),
      .peak_code(peak_code), .col_sel(col_sel), .row_en(row_en), .peak_out(peak_out));

   dmx_column_refresh #(.TICK_DIV(3)) i_dmx_column_refresh_div (
      .clk(clk), .rst_n(rst_n), .dot_latch(dot_latch), .duty(duty), .sleep(sleep),
      .peak_code(peak_code), .col_sel(col_sel_d), .row_en(row_en_d), .peak_out(peak_out_d));

   // cycle model built from R2..R9
   int           m_pos, m_col, d_cnt, d_pos, d_col;
   logic [159:0] m_img;
   logic [19:0]  e_col, e_col_d;
   logic [6:0]   e_row;
   logic [1:0]   e_peak;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_pos = 0; m_col = 0; m_img = '0; d_cnt = 0; d_pos = 0; d_col = 0;
         e_col = '0; e_row = '0; e_peak = '0; e_col_d = '0;
      end else begin
         e_peak = peak_code;
         e_col  = sleep ? 20'd0 : (20'd1 << m_col);
         e_row  = (!sleep && m_pos < int'(duty)) ? m_img[m_col*8+1 +: 7] : 7'd0;
         e_col_d = sleep ? 20'd0 : (20'd1 << d_col);
         if (m_pos == 15 && m_col == NC-1) m_img = dot_latch;
         if (m_pos == 15) m_col = (m_col == NC-1) ? 0 : m_col + 1;
         m_pos = (m_pos + 1) % 16;
         if (d_cnt == 2) begin
            if (d_pos == 15) d_col = (d_col == NC-1) ? 0 : d_col + 1;
            d_pos = (d_pos + 1) % 16;
            d_cnt = 0;
         end else d_cnt++;
      end
   end

   task automatic check(input string req, input string what, input logic [31:0] act,
                        input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h t=%0t", req, what, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (checking && rst_n) begin
         check("R2", "col_sel", 32'(col_sel), 32'(e_col));
         check(row_tag, "row_en", 32'(row_en), 32'(e_row));
         check("R8", "peak_out", 32'(peak_out), 32'(e_peak));
         check("R9", "col_sel prescaled", 32'(col_sel_d), 32'(e_col_d));
      end
   end

   function automatic logic [159:0] pattern(input int seed);
      logic [159:0] v;
      for (int b = 0; b < 20; b++) v[b*8 +: 8] = 8'((b * 37 + seed * 11 + 5) & 255);
      return v;
   endfunction

   task automatic run_all();
      int lit;
      // R1: reset state
      repeat (4) @(negedge clk);
      check("R1", "col_sel in reset", 32'(col_sel), 0);
      check("R1", "row_en in reset", 32'(row_en), 0);
      check("R1", "peak_out in reset", 32'(peak_out), 0);
      dot_latch = pattern(1); duty = 4'd15; peak_code = 2'd1;
      rst_n = 1'b1; checking = 1'b1;
      repeat (2) @(negedge clk);
      // R7: first frame is dark, column 0 active
      check("R7", "first frame rows", 32'(row_en), 0);
      check("R3", "first column onehot", 32'(col_sel), 1);
      row_tag = "R7";
      repeat (500) @(negedge clk);
      dot_latch = pattern(2);            // mid-frame change
      repeat (150) @(negedge clk);
      dot_latch = pattern(3);            // near the last slot
      peak_code = 2'd3;
      repeat (700) @(negedge clk);
      // R5: duty sweep with an all-ones image
      row_tag = "R5";
      dot_latch = '1;
      repeat (660) @(negedge clk);
      for (int d = 0; d < 16; d++) begin
         duty = 4'(d); peak_code = 2'(d);
         repeat (20) @(negedge clk);
         lit = 0;
         for (int k = 0; k < 16; k++) begin
            if (row_en == 7'h7F) lit++;
            @(negedge clk);
         end
         check("R5", "lit ticks per slot", 32'(lit), 32'(d));
      end
      // R4: only row 0 set, nothing must light
      row_tag = "R4";
      duty = 4'd15;
      dot_latch = {20{8'h01}};
      repeat (700) @(negedge clk);
      lit = 0;
      for (int k = 0; k < 320; k++) begin
         if (row_en != 0) lit++;
         @(negedge clk);
      end
      check("R4", "row 0 never driven", 32'(lit), 0);
      dot_latch = {20{8'hFE}};
      repeat (700) @(negedge clk);
      check("R4", "rows 1..7 all on", 32'(row_en), 32'h7F);
      // R6: sleep blanks, scan keeps moving
      row_tag = "R6";
      dot_latch = pattern(4);
      repeat (37) @(negedge clk);
      sleep = 1'b1;
      @(negedge clk);
      for (int k = 0; k < 200; k++) begin
         check("R6", "col_sel asleep", 32'(col_sel), 0);
         @(negedge clk);
      end
      sleep = 1'b0;
      repeat (500) @(negedge clk);
      for (int k = 0; k < 6; k++) begin
         sleep = ~sleep; duty = 4'(k * 3);
         repeat (53) @(negedge clk);
      end
      sleep = 1'b0;
      repeat (400) @(negedge clk);
   endtask

   initial begin
      fork
         run_all();
         begin
            repeat (150000) @(posedge clk);
            errors++;
            $display("FAIL watchdog expired");
         end
      join_any
      checking = 1'b0;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule